// File: doc/BRIEF.md
# Dithered Pulse-Width DAC (14-bit)

This block turns a 14-bit code into a single pulse-width output whose average level, after an external low-pass filter, is proportional to the code. The code is split into a coarse field of 8 bits and a fine field of 6 bits. The coarse field sets how many ticks each short sub-period of 256 ticks stays high. The fine field adds one extra high tick to a spread-out subset of the 64 sub-periods in a full repeat period. The spreading follows a bit-reversed pattern, so the extra energy is distributed as evenly as possible instead of bunching up.

Software writes the coarse byte first and the fine field second. Only the fine-field write moves the pair into the active value, which is what the readback ports show. The counters pick up an active value only at the start of a repeat period, so no period ever mixes two codes. Ticks are the clock divided by a parameter (2 by default). A count-disable input freezes the counters and holds the output at its inactive level. A polarity input inverts the pin.

Top module: `pwm_dither_dac`

## Requirements
- R1: A write to the coarse byte (`wr_hi`) alone changes neither `rd_hi` nor `rd_lo`.
- R2: On a fine-field write (`wr_lo`), the active value becomes {last coarse byte written, `wr_data[FW-1:0]`}. Both readback ports show it in the next cycle, and the upper bits of `wr_data` are ignored.
- R3: While `cnt_off` is 0, one tick occurs every DIV clocks. A sub-period lasts 2^CW ticks and a repeat period lasts 2^FW sub-periods, counted from reset.
- R4: In sub-period m, the output is active for the first DH + x(m) ticks and inactive for the rest, where DH is the coarse field and x(m) is 0 or 1.
- R5: x(m) = 1 exactly when m is nonzero and fine bit FW-1-z is set, where z is the index of the lowest set bit of m (bit 0 is the LSB of the fine field). Fine bit 0 selects only m = 2^(FW-1), and the top fine bit selects every odd m. Over one repeat period the active tick count is therefore DH*2^FW + DL.
- R6: With DH at its maximum, a selected sub-period is active for all of its ticks.
- R7: The active value is used starting at the next repeat-period boundary. A fine-field write on the very edge that starts a period takes effect only at the boundary after that.
- R8: While `cnt_off` is 1, the counters hold and the output stays at its inactive level. Counting resumes from the held position.
- R9: `pol` = 1 inverts the output, so the active level becomes 0.
- R10: After reset, the active, pending and counting values are all zero and the output is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_hi | input | 1 | Write the pending coarse byte |
| wr_lo | input | 1 | Write the fine field and transfer the full value |
| wr_data | input | max(CW,FW) | Write data |
| cnt_off | input | 1 | 1 stops the tick source |
| pol | input | 1 | 1 inverts the output |
| rd_hi | output | CW | Active coarse field |
| rd_lo | output | FW | Active fine field |
| pwm_out | output | 1 | PWM pin |

## Verification
Two events can land on the same clock edge: a fine-field transfer and the repeat-period boundary that loads the counters. The bench watches the edge count and raises `wr_lo` so that it is sampled on exactly the boundary edge. It then judges the period that follows by its active-tick total, which must still match the old code. The total must match the new code one period later. A cycle-exact model of the expected waveform runs during the whole test, including the frozen stretches and inverted-polarity stretches, so a wrong boundary shows up as a mismatch.

// File: rtl/pwm_dither_dac.sv
module pwm_dither_dac #(
  parameter int CW  = 8,
  parameter int FW  = 6,
  parameter int DIV = 2,
  localparam int DW = (CW > FW) ? CW : FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] wr_data,
  input  logic          cnt_off,
  input  logic          pol,
  output logic [CW-1:0] rd_hi,
  output logic [FW-1:0] rd_lo,
  output logic          pwm_out
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] pend_hi, act_hi, run_hi, slot;
  logic [FW-1:0] act_lo, run_lo, sub, fine_sel;
  logic [PW-1:0] pre;
  logic          tick, extra, on;
  logic [CW:0]   hi_time;

  assign tick = !cnt_off && (pre == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi <= '0;
      act_hi  <= '0;
      act_lo  <= '0;
      run_hi  <= '0;
      run_lo  <= '0;
      pre     <= '0;
      slot    <= '0;
      sub     <= '0;
    end else begin
      if (wr_hi) pend_hi <= wr_data[CW-1:0];
      if (wr_lo) begin
        act_hi <= pend_hi;
        act_lo <= wr_data[FW-1:0];
      end
      if (!cnt_off) pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        slot <= slot + 1'b1;
        if (&slot) begin
          sub <= sub + 1'b1;
          if (&sub) begin
            run_hi <= act_hi;
            run_lo <= act_lo;
          end
        end
      end
    end
  end

  always_comb begin
    fine_sel = '0;
    for (int k = 0; k < FW; k++) begin
      if (sub[FW-1-k] && ((sub & FW'((FW'(1) << (FW-1-k)) - FW'(1))) == '0))
        fine_sel[k] = 1'b1;
    end
  end

  assign extra   = |(run_lo & fine_sel);
  assign hi_time = {1'b0, run_hi} + (CW+1)'(extra);
  assign on      = !cnt_off && ({1'b0, slot} < hi_time);
  assign pwm_out = pol ^ on;
  assign rd_hi   = act_hi;
  assign rd_lo   = act_lo;
endmodule

// File: rtl/pwm_dither_dac_chk.sv
module pwm_dither_dac_chk #(
  parameter int CW = 8,
  parameter int FW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_lo,
  input logic [DW-1:0] wr_data,
  input logic          cnt_off,
  input logic          pol,
  input logic [CW-1:0] rd_hi,
  input logic [FW-1:0] rd_lo,
  input logic          pwm_out,
  input logic [CW-1:0] run_hi,
  input logic [FW-1:0] run_lo,
  input logic [CW-1:0] slot,
  input logic [FW-1:0] sub
);
  a_r1_hold_readback: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_lo) |-> $stable(rd_hi));

  a_r2_transfer_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_lo) |-> (rd_lo == $past(wr_data[FW-1:0])));

  a_r7_run_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_off || !(&slot) || !(&sub)) |-> $stable({run_hi, run_lo}));

  a_r8_freeze_counters: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_off) |-> $stable({slot, sub}));

  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_off |-> (pwm_out == pol));

  a_r4_zero_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run_hi == '0 && run_lo == '0) |-> (pwm_out == pol));
endmodule

bind pwm_dither_dac pwm_dither_dac_chk #(.CW(CW), .FW(FW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_data(wr_data),
  .cnt_off(cnt_off), .pol(pol), .rd_hi(rd_hi), .rd_lo(rd_lo),
  .pwm_out(pwm_out), .run_hi(run_hi), .run_lo(run_lo),
  .slot(slot), .sub(sub)
);

// File: tb/pwm_dither_dac_test.sv
module pwm_dither_dac_test;
  localparam int CLK_NS = 10;
  localparam int CW = 4, FW = 3, DIV = 2;
  localparam int DW = (CW > FW) ? CW : FW;
  localparam int S = 1 << CW, M = 1 << FW;
  localparam int P_CLK = DIV * S * M;

  logic clk = 0, rst_n = 0, wr_hi = 0, wr_lo = 0, cnt_off = 0, pol = 0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] rd_hi;
  logic [FW-1:0] rd_lo;
  logic pwm_out;

  pwm_dither_dac #(.CW(CW), .FW(FW), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .cnt_off(cnt_off), .pol(pol), .rd_hi(rd_hi), .rd_lo(rd_lo), .pwm_out(pwm_out));

  always #(CLK_NS/2) clk = ~clk;

  int errors = 0, checks = 0, mism = 0, hicnt = 0;
  int e = 0;
  logic [CW+FW-1:0] ex_pend_act, ex_act, ex_run;
  logic [CW-1:0] ex_pend;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e <= 0; ex_pend <= '0; ex_act <= '0; ex_run <= '0;
    end else begin
      if (wr_hi) ex_pend <= wr_data[CW-1:0];
      if (wr_lo) ex_act <= {ex_pend, wr_data[FW-1:0]};
      if (!cnt_off) begin
        e <= e + 1;
        if ((e + 1) % P_CLK == 0) ex_run <= ex_act;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int t, sl, m, dh, dl, x, z;
      logic exp;
      t = e / DIV; sl = t % S; m = (t / S) % M;
      dh = int'(ex_run[CW+FW-1:FW]); dl = int'(ex_run[FW-1:0]);
      x = 0;
      if (m != 0) begin
        z = 0;
        while (((m >> z) & 1) == 0) z++;
        x = (dl >> (FW - 1 - z)) & 1;
      end
      exp = pol ^ (!cnt_off && (sl < dh + x));
      if (pwm_out !== exp) mism++;
      if (pwm_out ^ pol) hicnt++;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input bit hi, input int d);
    step();
    wr_data = DW'(d);
    if (hi) wr_hi = 1; else wr_lo = 1;
    step();
    wr_hi = 0; wr_lo = 0;
  endtask

  task automatic align(); while (e % P_CLK != 0) step(); endtask

  task automatic measure(input string req, input int exp_hi);
    align();
    mism = 0; hicnt = 0;
    repeat (P_CLK) step();
    check(mism == 0, req, mism, 0);
    check(hicnt == exp_hi, req, hicnt, exp_hi);
  endtask

  initial begin
    #(CLK_NS * 190000);
    check(0, "watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(rd_hi == 0 && rd_lo == 0, "R10 readback", int'({rd_hi, rd_lo}), 0);
    check(pwm_out == 0, "R10 output", int'(pwm_out), 0);
    rst_n = 1;
    step();
    check(pwm_out == 0, "R10 output after release", int'(pwm_out), 0);

    wr(1, 9);
    check(rd_hi == 0, "R1 pending hidden", int'(rd_hi), 0);
    check(rd_lo == 0, "R1 low untouched", int'(rd_lo), 0);
    wr(0, 'hD);
    check(rd_hi == 9, "R2 high transfer", int'(rd_hi), 9);
    check(rd_lo == 5, "R2 low transfer, upper data ignored", int'(rd_lo), 5);

    // R3 R4 R5 R6: full sweep of every code
    for (int v = 0; v < (1 << (CW + FW)); v++) begin
      int dh, dl;
      dh = v >> FW; dl = v & (M - 1);
      wr(1, dh);
      wr(0, dl);
      while (ex_run != (CW+FW)'(v)) step();
      if (dh == S - 1 && dl != 0) measure("R6 full sub-period", DIV * (dh * M + dl));
      else measure("R3/R4/R5 sweep", DIV * (dh * M + dl));
    end

    // R7: transfer lands on the boundary edge
    wr(1, 2); wr(0, 1);
    align(); step();
    while (e % P_CLK != P_CLK - 1) step();
    wr_data = DW'(6); wr_hi = 1; step(); wr_hi = 0;
    while (e % P_CLK != P_CLK - 1) step();
    wr_data = DW'(3); wr_lo = 1;
    step();
    wr_lo = 0;
    check(rd_hi == 6 && rd_lo == 3, "R7 readback on boundary", int'({rd_hi, rd_lo}), (6 << FW) | 3);
    check(e % P_CLK == 0, "R7 aligned", e % P_CLK, 0);
    measure("R7 old code kept", DIV * (2 * M + 1));
    measure("R7 new code next", DIV * (6 * M + 3));

    // R8: freeze mid-period
    mism = 0;
    repeat (37) step();
    cnt_off = 1;
    repeat (41) step();
    check(pwm_out == pol, "R8 idle level", int'(pwm_out), int'(pol));
    cnt_off = 0;
    repeat (50) step();
    check(mism == 0, "R8 freeze and resume", mism, 0);
    measure("R8 after resume", DIV * (6 * M + 3));

    // R9: inverted polarity
    step(); pol = 1;
    measure("R9 inverted", DIV * (6 * M + 3));
    wr(1, 0); wr(0, 0);
    while (ex_run != '0) step();
    step();
    check(pwm_out == 1, "R9 zero code inverted", int'(pwm_out), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule